// File: doc/BRIEF.md
# Parity-Checked Lai-Massey Round

This block wraps one 64-bit Lai-Massey round with a concurrent error-detection channel. The data arrives as two 32-bit halves. Each half carries a set of even-parity bits, and the 64-bit round key carries one such set per 32-bit half. The block forms the key-mixed input of the nonlinear round function. That function is a separate, replaceable unit whose result and its own predicted parity come back as inputs. The block then applies the two XOR stages and, unless this is the last round, the orthomorphism (when encrypting) or its inverse (when decrypting) on the left half.

For every stage the block predicts the parity of the result. Independently, it recomputes the parity from the data at four verifier points: the key-mixed word, the upper key half, the round-function result and the orthomorphism input. Any mismatch sets a sticky per-verifier status bit and a summary error flag. Only a synchronous clear resets them. The parameter `PG` sets the redundancy to 1, 2 or 4 parity bits per 32 bits. With 2 or 4 bits, the orthomorphism's output parity follows from the input parity groups and its verifier is omitted. A fault port lets a test environment force one bit of a chosen internal net to 0 in order to measure stuck-at-0 detection.

Top module: `lm_round_cedc`

## Requirements
- R1: `mix_o` equals `xl_i ^ xr_i ^ rk_i[31:0]` combinationally, and `mix_par_o` equals `xl_par_i ^ xr_par_i ^ rk_par_i[PG-1:0]`. Parity group g covers data bits [g*32/PG +: 32/PG], and a parity bit is the XOR of its group's bits (even parity).
- R2: When `valid_i` is high, each verifier that mismatches sets its bit in `chk_o` at the next clock edge: bit 0 key-mixed word, bit 1 upper key half, bit 2 round-function result, bit 3 orthomorphism input. The bits stay set and `err_o` is the OR of `chk_o`.
- R3: With `y = xr_i ^ f_i`, the registered right output is `y`, and its parity is `xr_par_i` XOR the parity recomputed from `f_i`. The parity on `f_par_i` is never used for it.
- R4: Encrypting and not last round: with `yl = xl_i ^ f_i`, `al = yl[31:16]`, `ar = yl[15:0]`, the left output is `{ar, ar^al}`. For PG=1 its parity is the parity of `al`.
- R5: Decrypting and not last round: the left output is `{al^ar, al}`. For PG=1 its parity is the parity of `ar`.
- R6: In the last round the left output is `yl` unchanged, and its parity is `xl_par_i` XOR the recomputed parity of `f_i`.
- R7: For PG of 2 or 4, the left parity groups are predicted from the group-wise parity of `yl`. Encrypting gives upper groups = `ar` groups and lower groups = `ar^al` groups. Decrypting gives upper groups = `al^ar` groups and lower groups = `al` groups. Bit 3 of `chk_o` never sets.
- R8: A parity bit on `xl_i`, `xr_i` or the low key half that disagrees with its data sets bit 0. A wrong parity bit on the high key half sets bit 1.
- R9: `f_par_i` differing from the parity of `f_i` sets bit 2.
- R10: For PG=1 and not last round, a mismatch between the parity of `yl` and its predicted parity sets bit 3. In the last round bit 3 is not set.
- R11: After reset all outputs and `chk_o` are 0. The output registers load only on cycles with `valid_i` high and otherwise hold.
- R12: With `fault_en_i` high, bit `fault_bit_i` of the net chosen by `fault_net_i` is forced to 0: 0 key-mixed word (also seen on `mix_o`), 1 left XOR result, 2 right XOR result, 3 none.
- R13: `clr_i` clears `chk_o` at the next edge. A mismatch on a valid cycle that also carries `clr_i` is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Round inputs valid; loads outputs and status |
| clr_i | input | 1 | Synchronous clear of the status bits |
| enc_i | input | 1 | 1 orthomorphism, 0 inverse orthomorphism |
| last_i | input | 1 | Last round, orthomorphism skipped |
| xl_i | input | 32 | Left half |
| xl_par_i | input | PG | Left half parity |
| xr_i | input | 32 | Right half |
| xr_par_i | input | PG | Right half parity |
| rk_i | input | 64 | Round key |
| rk_par_i | input | 2*PG | Round key parity, low half in bits [PG-1:0] |
| mix_o | output | 32 | Key-mixed word to the round function |
| mix_par_o | output | PG | Predicted parity of `mix_o` |
| f_i | input | 32 | Round-function result |
| f_par_i | input | PG | Round-function predicted parity |
| fault_en_i | input | 1 | Enable stuck-at-0 forcing |
| fault_net_i | input | 2 | Net selector for forcing |
| fault_bit_i | input | 5 | Bit index for forcing |
| yl_o | output | 32 | Registered left output |
| yl_par_o | output | PG | Registered left parity |
| yr_o | output | 32 | Registered right output |
| yr_par_o | output | PG | Registered right parity |
| chk_o | output | 4 | Sticky per-verifier status |
| err_o | output | 1 | OR of `chk_o` |

## Verification
On every cycle the assertions check that status bits stay set until a clear, that a clear without a new event empties them, that the output registers hold when no valid round is presented, and that the right output's parity agrees with its data whenever the incoming right parity was sound. The data transforms of both orthomorphism directions and the last round, the closed-form parity prediction for each redundancy level, which verifier fires for each corrupted parity, and the detection of forced stuck-at-0 bits can only be shown by the bench's scenarios. The bench compares two instances, one with one and one with four parity bits per half, against a behavioural model on every clock.

// File: rtl/lm_cedc_pkg.sv
`timescale 1ns/1ps
package lm_cedc_pkg;
  typedef enum logic [1:0] {
    FN_MIX   = 2'd0,
    FN_LEFT  = 2'd1,
    FN_RIGHT = 2'd2,
    FN_NONE  = 2'd3
  } fault_net_e;

  localparam int CHK_MIX = 0;
  localparam int CHK_KEY = 1;
  localparam int CHK_SUB = 2;
  localparam int CHK_ORT = 3;
  localparam int NCHK    = 4;
endpackage

// File: rtl/lm_grp_parity.sv
`timescale 1ns/1ps
// Even parity of each of PG equal groups of a data word.
module lm_grp_parity #(
  parameter int DW = 32,
  parameter int PG = 1
) (
  input  logic [DW-1:0] data_i,
  output logic [PG-1:0] par_o
);
  localparam int GW = DW / PG;

  for (genvar g = 0; g < PG; g++) begin : g_grp
    assign par_o[g] = ^data_i[g*GW +: GW];
  end
endmodule

// File: rtl/lm_par_verify.sv
`timescale 1ns/1ps
// Verifier: recomputes group parity and flags disagreement with prediction.
module lm_par_verify #(
  parameter int DW = 32,
  parameter int PG = 1
) (
  input  logic [DW-1:0] data_i,
  input  logic [PG-1:0] pred_i,
  output logic          mism_o
);
  logic [PG-1:0] recomp;

  lm_grp_parity #(.DW(DW), .PG(PG)) u_gp (
    .data_i (data_i),
    .par_o  (recomp)
  );

  assign mism_o = |(recomp ^ pred_i);
endmodule

// File: rtl/lm_ortho.sv
`timescale 1ns/1ps
// Orthomorphism / inverse on one half, with output parity prediction.
module lm_ortho #(
  parameter int DW = 32,
  parameter int PG = 1
) (
  input  logic [DW-1:0] y_i,
  input  logic [PG-1:0] yp_i,
  input  logic          enc_i,
  input  logic          last_i,
  output logic [DW-1:0] o_y,
  output logic [PG-1:0] o_p,
  output logic          chk_o
);
  localparam int QW = DW / 2;

  logic [QW-1:0] al;
  logic [QW-1:0] ar;

  assign al = y_i[DW-1:QW];
  assign ar = y_i[QW-1:0];

  always_comb begin
    if (last_i)     o_y = y_i;
    else if (enc_i) o_y = {ar, ar ^ al};
    else            o_y = {al ^ ar, al};
  end

  if (PG == 1) begin : g_single
    // One bit per half: output parity is one sub-half's parity taken from data,
    // so the whole word is verified against its prediction first.
    logic [1:0] hp;

    lm_grp_parity #(.DW(DW), .PG(2)) u_half (
      .data_i (y_i),
      .par_o  (hp)
    );

    always_comb begin
      if (last_i)     o_p = yp_i;
      else if (enc_i) o_p = hp[1];
      else            o_p = hp[0];
    end

    assign chk_o = ~last_i & (hp[1] ^ hp[0] ^ yp_i[0]);
  end else begin : g_multi
    // Group boundaries align with the sub-halves: prediction is closed form.
    localparam int HP = PG / 2;
    logic [HP-1:0] pl;
    logic [HP-1:0] pr;

    assign pl = yp_i[PG-1:HP];
    assign pr = yp_i[HP-1:0];

    always_comb begin
      if (last_i)     o_p = yp_i;
      else if (enc_i) o_p = {pr, pr ^ pl};
      else            o_p = {pl ^ pr, pl};
    end

    assign chk_o = 1'b0;
  end
endmodule

// File: rtl/lm_round_cedc.sv
`timescale 1ns/1ps
module lm_round_cedc
  import lm_cedc_pkg::*;
#(
  parameter int DW = 32,
  parameter int PG = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_i,
  input  logic                  clr_i,
  input  logic                  enc_i,
  input  logic                  last_i,
  input  logic [DW-1:0]         xl_i,
  input  logic [PG-1:0]         xl_par_i,
  input  logic [DW-1:0]         xr_i,
  input  logic [PG-1:0]         xr_par_i,
  input  logic [2*DW-1:0]       rk_i,
  input  logic [2*PG-1:0]       rk_par_i,
  output logic [DW-1:0]         mix_o,
  output logic [PG-1:0]         mix_par_o,
  input  logic [DW-1:0]         f_i,
  input  logic [PG-1:0]         f_par_i,
  input  logic                  fault_en_i,
  input  logic [1:0]            fault_net_i,
  input  logic [$clog2(DW)-1:0] fault_bit_i,
  output logic [DW-1:0]         yl_o,
  output logic [PG-1:0]         yl_par_o,
  output logic [DW-1:0]         yr_o,
  output logic [PG-1:0]         yr_par_o,
  output logic [NCHK-1:0]       chk_o,
  output logic                  err_o
);
  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // Stuck-at-0 forcing masks.
  fault_net_e    fnet;
  logic [DW-1:0] fmask;
  logic [DW-1:0] mask_mix;
  logic [DW-1:0] mask_left;
  logic [DW-1:0] mask_right;

  assign fnet       = fault_net_e'(fault_net_i);
  assign fmask      = fault_en_i ? ({{(DW-1){1'b0}}, 1'b1} << fault_bit_i) : '0;
  assign mask_mix   = (fnet == FN_MIX)   ? fmask : '0;
  assign mask_left  = (fnet == FN_LEFT)  ? fmask : '0;
  assign mask_right = (fnet == FN_RIGHT) ? fmask : '0;

  // Key mixing stage (pure XOR: parity is XOR of operand parities).
  logic [DW-1:0] mix_d;
  logic [PG-1:0] mix_p;

  assign mix_d     = (xl_i ^ xr_i ^ rk_i[DW-1:0]) & ~mask_mix;
  assign mix_p     = xl_par_i ^ xr_par_i ^ rk_par_i[PG-1:0];
  assign mix_o     = mix_d;
  assign mix_par_o = mix_p;

  logic [NCHK-1:0] chk_now;

  lm_par_verify #(.DW(DW), .PG(PG)) u_vmix (
    .data_i (mix_d),
    .pred_i (mix_p),
    .mism_o (chk_now[CHK_MIX])
  );

  lm_par_verify #(.DW(DW), .PG(PG)) u_vkey (
    .data_i (rk_i[2*DW-1:DW]),
    .pred_i (rk_par_i[2*PG-1:PG]),
    .mism_o (chk_now[CHK_KEY])
  );

  // Round-function result: parity recomputed from data re-enters the channel.
  logic [PG-1:0] f_rp;

  lm_grp_parity #(.DW(DW), .PG(PG)) u_fpar (
    .data_i (f_i),
    .par_o  (f_rp)
  );
  assign chk_now[CHK_SUB] = |(f_rp ^ f_par_i);

  // XOR stages.
  logic [DW-1:0] yl_d;
  logic [PG-1:0] yl_p;
  logic [DW-1:0] yr_d;
  logic [PG-1:0] yr_p;

  assign yl_d = (xl_i ^ f_i) & ~mask_left;
  assign yl_p = xl_par_i ^ f_rp;
  assign yr_d = (xr_i ^ f_i) & ~mask_right;
  assign yr_p = xr_par_i ^ f_rp;

  // Orthomorphism stage.
  logic [DW-1:0] ol_d;
  logic [PG-1:0] ol_p;

  lm_ortho #(.DW(DW), .PG(PG)) u_ortho (
    .y_i    (yl_d),
    .yp_i   (yl_p),
    .enc_i  (enc_i),
    .last_i (last_i),
    .o_y    (ol_d),
    .o_p    (ol_p),
    .chk_o  (chk_now[CHK_ORT])
  );

  // Next state.
  logic [DW-1:0]   yl_q, yl_n;
  logic [PG-1:0]   ylp_q, ylp_n;
  logic [DW-1:0]   yr_q, yr_n;
  logic [PG-1:0]   yrp_q, yrp_n;
  logic [NCHK-1:0] chk_q, chk_n;

  always_comb begin
    yl_n  = yl_q;
    ylp_n = ylp_q;
    yr_n  = yr_q;
    yrp_n = yrp_q;
    if (valid_i) begin
      yl_n  = ol_d;
      ylp_n = ol_p;
      yr_n  = yr_d;
      yrp_n = yr_p;
    end
    chk_n = (clr_i ? '0 : chk_q) | (valid_i ? chk_now : '0);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      yl_q  <= '0;
      ylp_q <= '0;
      yr_q  <= '0;
      yrp_q <= '0;
      chk_q <= '0;
    end else begin
      yl_q  <= yl_n;
      ylp_q <= ylp_n;
      yr_q  <= yr_n;
      yrp_q <= yrp_n;
      chk_q <= chk_n;
    end
  end

  assign yl_o     = yl_q;
  assign yl_par_o = ylp_q;
  assign yr_o     = yr_q;
  assign yr_par_o = yrp_q;
  assign chk_o    = chk_q;
  assign err_o    = |chk_q;

  // Assertion support: parities recomputed on ports.
  logic [PG-1:0] xr_rp;
  logic [PG-1:0] yr_out_rp;

  lm_grp_parity #(.DW(DW), .PG(PG)) u_a_xr (
    .data_i (xr_i),
    .par_o  (xr_rp)
  );

  lm_grp_parity #(.DW(DW), .PG(PG)) u_a_yr (
    .data_i (yr_q),
    .par_o  (yr_out_rp)
  );

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    !clr_i |=> ((chk_q & $past(chk_q)) == $past(chk_q)));

  a_r13_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clr_i && !valid_i) |=> (chk_q == '0));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !valid_i |=> ($stable(yl_q) && $stable(ylp_q) && $stable(yr_q) && $stable(yrp_q)));

  a_r3_right_parity: assert property (@(posedge clk) disable iff (!rst_n_s)
    (valid_i && (xr_par_i == xr_rp) && !(fault_en_i && fnet == FN_RIGHT))
      |=> (yr_par_o == yr_out_rp));
endmodule

// File: tb/lm_round_cedc_tb.sv
`timescale 1ns/1ps
module lm_round_cedc_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic        valid, clr, enc, last, fen;
  logic [1:0]  fnet;
  logic [4:0]  fbit;
  logic [31:0] xl, xr, f;
  logic [63:0] rk;

  logic [0:0]  xlp1, xrp1, fp1;
  logic [1:0]  rkp1;
  logic [3:0]  xlp4, xrp4, fp4;
  logic [7:0]  rkp4;

  logic [31:0] mix1, yl1, yr1, mix4, yl4, yr4;
  logic [0:0]  mixp1, ylp1, yrp1;
  logic [3:0]  mixp4, ylp4, yrp4, chk1, chk4;
  logic        err1, err4;

  lm_round_cedc #(.DW(32), .PG(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .clr_i(clr), .enc_i(enc), .last_i(last),
    .xl_i(xl), .xl_par_i(xlp1), .xr_i(xr), .xr_par_i(xrp1), .rk_i(rk), .rk_par_i(rkp1),
    .mix_o(mix1), .mix_par_o(mixp1), .f_i(f), .f_par_i(fp1),
    .fault_en_i(fen), .fault_net_i(fnet), .fault_bit_i(fbit),
    .yl_o(yl1), .yl_par_o(ylp1), .yr_o(yr1), .yr_par_o(yrp1), .chk_o(chk1), .err_o(err1));

  lm_round_cedc #(.DW(32), .PG(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .clr_i(clr), .enc_i(enc), .last_i(last),
    .xl_i(xl), .xl_par_i(xlp4), .xr_i(xr), .xr_par_i(xrp4), .rk_i(rk), .rk_par_i(rkp4),
    .mix_o(mix4), .mix_par_o(mixp4), .f_i(f), .f_par_i(fp4),
    .fault_en_i(fen), .fault_net_i(fnet), .fault_bit_i(fbit),
    .yl_o(yl4), .yl_par_o(ylp4), .yr_o(yr4), .yr_par_o(yrp4), .chk_o(chk4), .err_o(err4));

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model state, index 0: one bit per half, index 1: four bits.
  logic [31:0] e_yl [2];
  logic [3:0]  e_ylp[2];
  logic [31:0] e_yr [2];
  logic [3:0]  e_yrp[2];
  logic [3:0]  e_chk[2];

  function automatic logic [3:0] gpar(input logic [31:0] d, input int pg);
    logic [3:0] p = '0;
    int w = 32 / pg;
    for (int g = 0; g < pg; g++)
      for (int b = 0; b < w; b++) p[g] = p[g] ^ d[g*w + b];
    return p;
  endfunction

  task automatic chk(input string scen, input string req, input int k,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s dut%0d: actual %h expected %h", req, scen, k, act, exp);
    end
  endtask

  task automatic compare_all(input string scen, input string lt, input string lpt);
    chk(scen, lt,   0, {32'b0, yl1},  {32'b0, e_yl[0]});
    chk(scen, lpt,  0, {63'b0, ylp1}, {63'b0, e_ylp[0][0]});
    chk(scen, "R3", 0, {32'b0, yr1},  {32'b0, e_yr[0]});
    chk(scen, "R3", 0, {63'b0, yrp1}, {63'b0, e_yrp[0][0]});
    chk(scen, "R2", 0, {60'b0, chk1}, {60'b0, e_chk[0]});
    chk(scen, "R2", 0, {63'b0, err1}, {63'b0, |e_chk[0]});
    chk(scen, lt,   1, {32'b0, yl4},  {32'b0, e_yl[1]});
    chk(scen, (lpt == "R6") ? "R6" : "R7", 1, {60'b0, ylp4}, {60'b0, e_ylp[1]});
    chk(scen, "R3", 1, {32'b0, yr4},  {32'b0, e_yr[1]});
    chk(scen, "R3", 1, {60'b0, yrp4}, {60'b0, e_yrp[1]});
    chk(scen, "R2", 1, {60'b0, chk4}, {60'b0, e_chk[1]});
    chk(scen, "R2", 1, {63'b0, err4}, {63'b0, |e_chk[1]});
  endtask

  // flip: [0] xl, [1] xr, [2] rk low, [3] rk high, [4] f parity (group 0).
  task automatic step(input string scen, input logic v, input logic c, input logic e,
                      input logic l, input logic [31:0] a, input logic [31:0] b,
                      input logic [63:0] key, input logic [31:0] ff, input logic [4:0] flip,
                      input logic fe, input logic [1:0] fn, input logic [4:0] fb);
    logic [3:0] pa, pb, pkl, pkh, pf;
    logic [3:0] xlpk, xrpk, rklk, rkhk, fpk;
    logic [31:0] mask, mixm, y, r, ol;
    logic [3:0] mp, frp, yp, rp, olp, c_now, pl, pr;
    int pg, h;
    string lt, lpt;
    valid = v; clr = c; enc = e; last = l;
    xl = a; xr = b; rk = key; f = ff;
    fen = fe; fnet = fn; fbit = fb;
    pa = gpar(a, 1);  pb = gpar(b, 1);  pkl = gpar(key[31:0], 1);
    pkh = gpar(key[63:32], 1); pf = gpar(ff, 1);
    xlp1 = pa[0] ^ flip[0]; xrp1 = pb[0] ^ flip[1];
    rkp1 = {pkh[0] ^ flip[3], pkl[0] ^ flip[2]}; fp1 = pf[0] ^ flip[4];
    xlp4 = gpar(a, 4) ^ {3'b0, flip[0]};
    xrp4 = gpar(b, 4) ^ {3'b0, flip[1]};
    rkp4 = {gpar(key[63:32], 4) ^ {3'b0, flip[3]}, gpar(key[31:0], 4) ^ {3'b0, flip[2]}};
    fp4  = gpar(ff, 4) ^ {3'b0, flip[4]};
    #1;
    for (int k = 0; k < 2; k++) begin
      pg = (k == 0) ? 1 : 4;
      if (k == 0) begin
        xlpk = {3'b0, xlp1}; xrpk = {3'b0, xrp1}; rklk = {3'b0, rkp1[0]};
        rkhk = {3'b0, rkp1[1]}; fpk = {3'b0, fp1};
      end else begin
        xlpk = xlp4; xrpk = xrp4; rklk = rkp4[3:0]; rkhk = rkp4[7:4]; fpk = fp4;
      end
      mask = fe ? (32'h1 << fb) : 32'h0;
      mixm = (a ^ b ^ key[31:0]) & ~((fn == 2'd0) ? mask : 32'h0);
      mp   = xlpk ^ xrpk ^ rklk;
      if (k == 0) begin
        chk(scen, "R1", 0, {32'b0, mix1}, {32'b0, mixm});
        chk(scen, "R1", 0, {63'b0, mixp1}, {63'b0, mp[0]});
      end else begin
        chk(scen, "R1", 1, {32'b0, mix4}, {32'b0, mixm});
        chk(scen, "R1", 1, {60'b0, mixp4}, {60'b0, mp});
      end
      frp = gpar(ff, pg);
      y   = (a ^ ff) & ~((fn == 2'd1) ? mask : 32'h0);
      yp  = xlpk ^ frp;
      r   = (b ^ ff) & ~((fn == 2'd2) ? mask : 32'h0);
      rp  = xrpk ^ frp;
      if (l)      ol = y;
      else if (e) ol = {y[15:0], y[15:0] ^ y[31:16]};
      else        ol = {y[31:16] ^ y[15:0], y[31:16]};
      if (l) olp = yp;
      else if (pg == 1) begin
        olp = e ? {3'b0, ^y[31:16]} : {3'b0, ^y[15:0]};
      end else begin
        h  = pg / 2;
        pl = (yp >> h) & 4'((1 << h) - 1);
        pr = yp & 4'((1 << h) - 1);
        olp = e ? ((pr << h) | (pr ^ pl)) : (((pl ^ pr) << h) | pl);
      end
      c_now[0] = (gpar(mixm, pg) != mp);
      c_now[1] = (gpar(key[63:32], pg) != rkhk);
      c_now[2] = (frp != fpk);
      c_now[3] = (pg == 1) && !l && (gpar(y, 1) != yp);
      if (v) begin
        e_yl[k] = ol; e_ylp[k] = olp; e_yr[k] = r; e_yrp[k] = rp;
      end
      e_chk[k] = (c ? 4'b0 : e_chk[k]) | (v ? c_now : 4'b0);
    end
    lt  = !v ? "R11" : (l ? "R6" : (e ? "R4" : "R5"));
    lpt = lt;
    @(posedge clk);
    @(negedge clk);
    compare_all(scen, lt, lpt);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      e_yl[k] = '0; e_ylp[k] = '0; e_yr[k] = '0; e_yrp[k] = '0; e_chk[k] = '0;
    end
    rst_n = 1'b0; valid = 0; clr = 0; enc = 1; last = 0; fen = 0; fnet = 2'd3; fbit = 0;
    xl = 0; xr = 0; f = 0; rk = 0;
    xlp1 = 0; xrp1 = 0; fp1 = 0; rkp1 = 0; xlp4 = 0; xrp4 = 0; fp4 = 0; rkp4 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R11 reset state", "R11", "R11");

    step("R4 encrypt clean", 1, 0, 1, 0, 32'h1234_5678, 32'h9ABC_DEF0,
         64'h0F1E_2D3C_4B5A_6978, 32'hCAFE_F00D, 5'b0, 0, 2'd3, 0);
    step("R5 decrypt clean", 1, 0, 0, 0, 32'hDEAD_BEEF, 32'h0BAD_F00D,
         64'h1111_2222_3333_4444, 32'h5555_AAAA, 5'b0, 0, 2'd3, 0);
    step("R6 last clean", 1, 0, 1, 1, 32'h0000_FFFF, 32'h8000_0001,
         64'hFFFF_0000_FFFF_0000, 32'h7F7F_0101, 5'b0, 0, 2'd3, 0);
    step("R7 decrypt grouped", 1, 0, 0, 0, 32'hA5A5_0F0F, 32'h3C3C_C3C3,
         64'h0123_4567_89AB_CDEF, 32'h0000_0001, 5'b0, 0, 2'd3, 0);
    step("R11 hold", 0, 0, 1, 0, 32'hFFFF_FFFF, 32'h1, 64'h5, 32'h7, 5'b0, 0, 2'd3, 0);
    step("R8 xl parity bad", 1, 0, 1, 0, 32'h1357_9BDF, 32'h2468_ACE0,
         64'h0, 32'h0F0F_0F0F, 5'b00001, 0, 2'd3, 0);
    step("R13 clear", 0, 1, 1, 0, 32'h0, 32'h0, 64'h0, 32'h0, 5'b0, 0, 2'd3, 0);
    step("R8 key high parity bad", 1, 0, 1, 0, 32'h1, 32'h2, 64'hF000_0000_0000_0003,
         32'h4, 5'b01000, 0, 2'd3, 0);
    step("R13 clear with event", 1, 1, 0, 0, 32'h11, 32'h22, 64'h33, 32'h44,
         5'b10000, 0, 2'd3, 0);
    step("R13 clear", 0, 1, 1, 0, 32'h0, 32'h0, 64'h0, 32'h0, 5'b0, 0, 2'd3, 0);
    step("R9 f parity bad", 1, 0, 1, 0, 32'h7777_0000, 32'h0000_7777,
         64'h0, 32'h8421_8421, 5'b10000, 0, 2'd3, 0);
    step("R13 clear", 0, 1, 1, 0, 32'h0, 32'h0, 64'h0, 32'h0, 5'b0, 0, 2'd3, 0);
    step("R10 R12 left stuck", 1, 0, 1, 0, 32'hFFFF_FFFF, 32'h0, 64'h0, 32'h0,
         5'b0, 1, 2'd1, 5'd7);
    step("R13 clear", 0, 1, 1, 0, 32'h0, 32'h0, 64'h0, 32'h0, 5'b0, 0, 2'd3, 0);
    step("R10 last left stuck", 1, 0, 1, 1, 32'hFFFF_FFFF, 32'h0, 64'h0, 32'h0,
         5'b0, 1, 2'd1, 5'd3);
    step("R12 mix stuck", 1, 0, 0, 0, 32'h0000_0100, 32'h0, 64'h0, 32'h0,
         5'b0, 1, 2'd0, 5'd8);
    step("R13 clear", 0, 1, 1, 0, 32'h0, 32'h0, 64'h0, 32'h0, 5'b0, 0, 2'd3, 0);
    step("R12 right stuck", 1, 0, 1, 0, 32'h0, 32'h8000_0000, 64'h0, 32'h0,
         5'b0, 1, 2'd2, 5'd31);

    for (int i = 0; i < 400; i++) begin
      logic [4:0] fl;
      fl = ($urandom % 8 == 0) ? 5'(1 << ($urandom % 5)) : 5'b0;
      step("random", ($urandom % 5) != 0, ($urandom % 6) == 0, $urandom % 2,
           ($urandom % 4) == 0, $urandom, $urandom, {$urandom, $urandom}, $urandom, fl,
           ($urandom % 10) == 0, 2'($urandom % 4), 5'($urandom % 32));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule